// File: doc/BRIEF.md
# Interrupt Pending and Mask Logic

This block holds the interrupt state of a processor's system-control unit. A 32-bit cause word carries eight pending bits, one per interrupt line, and a 32-bit status word carries a global enable and eight per-line mask bits. The block combines them into one hardware interrupt request for the core. Each pending bit follows the level last reported for its line. A per-line 64-bit counter records how often a line raised a request that was enabled.

Level changes arrive as events on one port. Each event names a line, a level and a numbering source. With core numbering the event index is the line number. With controller numbering the index is moved up by two, so an external controller never reaches lines 0 and 1, which software owns through writes to the cause word. Software reads and writes the registers through a single-address register port. Reads are combinational. Writes take effect at the clock edge.

There is no sequencing state in this block. Every register updates on every clock from its current value and the inputs of that cycle.

Top module: `irqc_top`

## Requirements
- R1: An event with `evt_vld`=1 to line n (0..7) sets cause bit 8+n when `evt_lvl`=1 and clears it when `evt_lvl`=0, one cycle later. The bit holds its value when no event targets it.
- R2: When `evt_ext`=0 the line is `evt_num`. When `evt_ext`=1 the line is `evt_num`+2, so external index k drives cause bit 10+k.
- R3: An event whose line, after the offset, is 8 or more changes no cause bit and no counter.
- R4: `irq_o` is 1 exactly when status bit 0 is 1 and, for at least one n, both cause bit 8+n and status bit 8+n are 1. It reflects register contents in the cycle after the write or event that changed them.
- R5: A write to address 0 (status) stores data bit 0 as the global enable and data bits 15:8 as the mask. A read of address 0 returns these bits, and all other bits read 0.
- R6: A write to address 1 (cause) loads only cause bits 9:8. Data bits 15:10 and all other bits are ignored. If an event targets line 0 or 1 in the same cycle as the write, the event decides that bit.
- R7: The counter of line n rises by one on each event to line n with `evt_lvl`=1 while the enable and mask bit 8+n, as held before that edge, are both 1. It reads as its low word at address 32+2n and its high word at address 33+2n.
- R8: Address 2 returns the pending byte in bits 7:0 and the mask byte in bits 15:8, with all other bits 0.
- R9: After reset, status, cause and all counters are 0. A read of any address not named above returns 0, and a write to such an address (or to address 2) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_vld | input | 1 | A line level event is presented |
| evt_ext | input | 1 | 1: index uses controller numbering (offset by two) |
| evt_num | input | 4 | Line index of the event |
| evt_lvl | input | 1 | New level of the line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Combined hardware interrupt request |

## Verification
The assertions assume that at most one line event arrives per cycle and that inputs are stable around the rising edge. They allow a register write and an event in the same cycle. The bench drives all inputs on the falling edge. It mixes directed cases with random cycles that include out-of-range indices, both numbering sources, and writes that coincide with events, and every cycle it compares the request and the read data against a behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register address map (address decode is part of the behaviour)
    localparam int unsigned STAT_ADDR  = 0;
    localparam int unsigned CAUSE_ADDR = 1;
    localparam int unsigned VIEW_ADDR  = 2;
    localparam int unsigned CNT_BASE   = 32;

    // Numbering source of an incoming line event
    typedef enum logic {
        SRC_CORE = 1'b0,
        SRC_EXT  = 1'b1
    } irq_src_e;

    // Decoded register selector
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CAUSE,
        SEL_VIEW,
        SEL_CNT_LO,
        SEL_CNT_HI
    } reg_sel_e;

endpackage

// File: rtl/irqc_line.sv
module irqc_line #(
    parameter int  CNT_W = 64,
    parameter bit  SOFT  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             lvl_i,
    input  logic             sw_we_i,
    input  logic             sw_val_i,
    input  logic             armed_i,
    output logic             pend_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic pend_q;
    logic pend_d;
    logic cnt_inc;

    generate
        if (SOFT) begin : g_soft
            // event beats a same-cycle software write
            assign pend_d = hit_i ? lvl_i : (sw_we_i ? sw_val_i : pend_q);
        end else begin : g_hw
            logic sw_unused;
            assign sw_unused = sw_we_i ^ sw_val_i;
            assign pend_d    = hit_i ? lvl_i : pend_q;

            // R6
            hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !hit_i |=> $stable(pend_o));
        end
    endgenerate

    assign cnt_inc = hit_i & lvl_i & armed_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_o  <= '0;
        end else begin
            pend_q <= pend_d;
            if (cnt_inc) begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end

    assign pend_o = pend_q;

    // R1
    follow_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (pend_o == $past(lvl_i)));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_i && lvl_i && armed_i) |=> $stable(cnt_o));

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int PEND_LSB  = 8,
    parameter int CNT_W     = 64,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6
) (
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic                              ie_i,
    input  logic [NUM_LINES-1:0]              mask_i,
    input  logic [NUM_LINES-1:0]              pend_i,
    input  logic [NUM_LINES-1:0][CNT_W-1:0]   cnt_i,
    output logic [DATA_W-1:0]                 rdata_o
);

    localparam int EXT_W = 2 * DATA_W;

    reg_sel_e          sel;
    logic [ADDR_W-1:0] cnt_off;
    logic [ADDR_W-1:0] cnt_idx;
    logic [CNT_W-1:0]  cnt_pick;
    logic [EXT_W-1:0]  cnt_ext;

    assign cnt_off = addr_i - ADDR_W'(CNT_BASE);
    assign cnt_idx = cnt_off >> 1;

    always_comb begin
        sel = SEL_NONE;
        if (addr_i == ADDR_W'(STAT_ADDR)) begin
            sel = SEL_STATUS;
        end else if (addr_i == ADDR_W'(CAUSE_ADDR)) begin
            sel = SEL_CAUSE;
        end else if (addr_i == ADDR_W'(VIEW_ADDR)) begin
            sel = SEL_VIEW;
        end else if (addr_i >= ADDR_W'(CNT_BASE) && cnt_idx < ADDR_W'(NUM_LINES)) begin
            sel = cnt_off[0] ? SEL_CNT_HI : SEL_CNT_LO;
        end
    end

    always_comb begin
        cnt_pick = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cnt_idx == ADDR_W'(i)) begin
                cnt_pick = cnt_i[i];
            end
        end
    end

    assign cnt_ext = EXT_W'(cnt_pick);

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_STATUS: begin
                rdata_o[0]                    = ie_i;
                rdata_o[PEND_LSB +: NUM_LINES] = mask_i;
            end
            SEL_CAUSE:  rdata_o[PEND_LSB +: NUM_LINES] = pend_i;
            SEL_VIEW: begin
                rdata_o[0 +: NUM_LINES]         = pend_i;
                rdata_o[NUM_LINES +: NUM_LINES] = mask_i;
            end
            SEL_CNT_LO: rdata_o = cnt_ext[DATA_W-1:0];
            SEL_CNT_HI: rdata_o = cnt_ext[EXT_W-1:DATA_W];
            SEL_NONE:   rdata_o = '0;
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter int SOFT_LINES = 2,
    parameter int PEND_LSB   = 8,
    parameter int CNT_W      = 64,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6,
    parameter int EVT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_vld,
    input  logic              evt_ext,
    input  logic [EVT_W-1:0]  evt_num,
    input  logic              evt_lvl,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    localparam int EFF_W = EVT_W + 1;

    irq_src_e                           evt_src;
    logic [EFF_W-1:0]                   eff_idx;
    logic                               in_range;
    logic                               wr_status;
    logic                               wr_cause;
    logic                               ie_q;
    logic [NUM_LINES-1:0]               mask_q;
    logic [NUM_LINES-1:0]               pend;
    logic [NUM_LINES-1:0][CNT_W-1:0]    cnt;
    logic                               wdata_unused;

    assign evt_src   = irq_src_e'(evt_ext);
    assign eff_idx   = {1'b0, evt_num} + ((evt_src == SRC_EXT) ? EFF_W'(SOFT_LINES) : '0);
    assign in_range  = eff_idx < EFF_W'(NUM_LINES);
    assign wr_status = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));
    assign wr_cause  = reg_wr && (reg_addr == ADDR_W'(CAUSE_ADDR));
    assign wdata_unused = ^reg_wdata;

    // Status register: global enable and per-line mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mask_q <= '0;
        end else if (wr_status) begin
            ie_q   <= reg_wdata[0];
            mask_q <= reg_wdata[PEND_LSB +: NUM_LINES];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
            irqc_line #(
                .CNT_W (CNT_W),
                .SOFT  (gi < SOFT_LINES)
            ) u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .hit_i    (evt_vld && in_range && (eff_idx == EFF_W'(gi))),
                .lvl_i    (evt_lvl),
                .sw_we_i  (wr_cause),
                .sw_val_i (reg_wdata[PEND_LSB + gi]),
                .armed_i  (ie_q & mask_q[gi]),
                .pend_o   (pend[gi]),
                .cnt_o    (cnt[gi])
            );
        end
    endgenerate

    assign irq_o = ie_q & (|(pend & mask_q));

    irqc_rdmux #(
        .NUM_LINES (NUM_LINES),
        .PEND_LSB  (PEND_LSB),
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_rdmux (
        .addr_i  (reg_addr),
        .ie_i    (ie_q),
        .mask_i  (mask_q),
        .pend_i  (pend),
        .cnt_i   (cnt),
        .rdata_o (reg_rdata)
    );

    // R3
    oor_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && !in_range && !wr_cause) |=> $stable(pend));

    // R4
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !evt_vld) |=> $stable(irq_o));

    // R5
    ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ($stable(ie_q) && $stable(mask_q)));

endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

    logic        clk;
    logic        rst_n;
    logic        evt_vld;
    logic        evt_ext;
    logic [3:0]  evt_num;
    logic        evt_lvl;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_o;

    irqc_top u_irqc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_vld   (evt_vld),
        .evt_ext   (evt_ext),
        .evt_num   (evt_num),
        .evt_lvl   (evt_lvl),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    // 50 MHz
    initial clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    string phase = "R9";

    // behavioural model state
    bit              m_ie;
    bit [7:0]        m_mask;
    bit [7:0]        m_pend;
    longint unsigned m_cnt [8];
    int              cur_addr;

    function automatic bit model_irq();
        return m_ie && ((m_pend & m_mask) != 8'h00);
    endfunction

    function automatic logic [31:0] model_read(input int a);
        logic [31:0] r;
        r = 32'h0;
        if (a == 0)      r = {16'h0, m_mask, 7'h0, m_ie};
        else if (a == 1) r = {16'h0, m_pend, 8'h00};
        else if (a == 2) r = {16'h0, m_mask, m_pend};
        else if (a >= 32 && a < 48) begin
            if (a % 2 == 0) r = m_cnt[(a - 32) / 2][31:0];
            else            r = m_cnt[(a - 32) / 2][63:32];
        end
        return r;
    endfunction

    function automatic string read_tag(input int a);
        if (a == 0) return "R5";
        if (a == 1) return "R1";
        if (a == 2) return "R8";
        if (a >= 32 && a < 48) return "R7";
        return "R9";
    endfunction

    task automatic compare();
        logic [31:0] exp_rd;
        checks++;
        if (irq_o !== model_irq()) begin
            fails++;
            $display("FAIL R4 (phase %s): irq_o actual %0b expected %0b", phase, irq_o, model_irq());
        end
        exp_rd = model_read(cur_addr);
        checks++;
        if (reg_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s (phase %s): addr %0d rdata actual %h expected %h",
                     read_tag(cur_addr), phase, cur_addr, reg_rdata, exp_rd);
        end
    endtask

    task automatic model_apply(input bit v, input bit x, input int n, input bit l,
                               input bit w, input int a, input logic [31:0] d);
        int  line;
        bit  old_ie;
        bit [7:0] old_mask;
        old_ie   = m_ie;
        old_mask = m_mask;
        line     = n + (x ? 2 : 0);
        if (w) begin
            if (a == 0) begin
                m_ie   = d[0];
                m_mask = d[15:8];
            end else if (a == 1) begin
                m_pend[1:0] = d[9:8];
            end
        end
        if (v && line < 8) begin
            if (l && old_ie && old_mask[line]) m_cnt[line]++;
            m_pend[line] = l;
        end
    endtask

    task automatic step(input bit v, input bit x, input int n, input bit l,
                        input bit w, input int a, input logic [31:0] d);
        @(negedge clk);
        compare();
        evt_vld   = v;
        evt_ext   = x;
        evt_num   = 4'(n);
        evt_lvl   = l;
        reg_wr    = w;
        reg_addr  = 6'(a);
        reg_wdata = d;
        model_apply(v, x, n, l, w, a, d);
        cur_addr = a;
    endtask

    task automatic idle_read(input int a);
        step(1'b0, 1'b0, 0, 1'b0, 1'b0, a, 32'h0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; evt_vld = 0; evt_ext = 0; evt_num = 0; evt_lvl = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        m_ie = 0; m_mask = 0; m_pend = 0; cur_addr = 0;
        for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state on every register
        phase = "R9";
        idle_read(0); idle_read(1); idle_read(2); idle_read(32); idle_read(47); idle_read(20);

        // R1: level follows for core line 3, no request while disabled
        phase = "R1";
        step(1, 0, 3, 1, 0, 1, 32'h0);
        idle_read(1);
        step(1, 0, 3, 0, 0, 1, 32'h0);
        idle_read(1);

        // R5: enable with all masks, then read status
        phase = "R5";
        step(0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
        idle_read(0);

        // R4 and R7: enabled request on line 5, counter readback
        phase = "R4";
        step(1, 0, 5, 1, 0, 42, 32'h0);
        idle_read(42); idle_read(43);
        step(1, 0, 5, 0, 0, 1, 32'h0);
        idle_read(1);

        // R2: controller index 3 lands on line 5, index 0 on line 2
        phase = "R2";
        step(1, 1, 3, 1, 0, 1, 32'h0);
        step(1, 1, 0, 1, 0, 1, 32'h0);
        idle_read(2); idle_read(36); idle_read(42);

        // R3: controller index 6 and core index 9 are out of range
        phase = "R3";
        step(1, 1, 6, 1, 0, 1, 32'h0);
        step(1, 0, 9, 1, 0, 1, 32'h0);
        step(1, 1, 15, 0, 0, 1, 32'h0);
        idle_read(1);

        // R6: only bits 9:8 take a write; event wins on line 0
        phase = "R6";
        step(0, 0, 0, 0, 1, 1, 32'hFFFF_FF00);
        idle_read(1);
        step(1, 0, 0, 0, 1, 1, 32'h0000_0300);
        idle_read(1);
        step(0, 0, 0, 0, 1, 1, 32'h0);
        idle_read(1);

        // R4: mask and enable changes drop the request
        phase = "R4";
        step(0, 0, 0, 0, 1, 0, 32'h0000_0001);
        idle_read(0);
        step(0, 0, 0, 0, 1, 0, 32'h0000_2400);
        idle_read(0);
        step(0, 0, 0, 0, 1, 0, 32'h0000_2401);
        idle_read(0);

        // R8 and R9: view and unmapped writes
        phase = "R8";
        step(0, 0, 0, 0, 1, 2, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, 33, 32'hFFFF_FFFF);
        idle_read(2); idle_read(33); idle_read(63);

        // random traffic across all requirements
        phase = "RAND";
        for (int k = 0; k < 3000; k++) begin
            int          a;
            int          pick;
            logic [31:0] d;
            pick = $urandom_range(0, 9);
            if (pick < 3)      a = pick;
            else if (pick < 8) a = 32 + $urandom_range(0, 15);
            else               a = $urandom_range(3, 63);
            if ($urandom_range(0, 3) == 0) a = $urandom_range(0, 1);
            d = $urandom;
            step($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 9), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 4) == 0, a, d);
        end
        idle_read(0);
        idle_read(0);
        finish_run();
    end

endmodule